// File: doc/BRIEF.md
# Latency-Hiding Thread Scheduler

This block decides, every cycle, which hardware thread feeds a single shared execution engine. It holds up to sixteen thread contexts. Each context has a program counter, a base offset into the register file and a two-bit tag naming the pipeline stage that created the thread (vertex, primitive or fragment work). All three kinds of thread share one pool of slots and are scheduled by the same rules.

A slot is free, ready or blocked. In each cycle the scheduler grants one ready slot in round-robin order and presents its ID, program counter, register base and tag to the engine. The engine decodes the instruction and answers in the same cycle with an operation code. The code either advances the thread, parks it on a memory reference, redirects it to a target address or retires it. A parked thread stays out of arbitration until the memory system names it on the return port. Memory latency is therefore covered by switching to other threads rather than by a cache. When no thread can run, the scheduler raises a stall.

Threads are created through a plain load port. The load is placed in the lowest-numbered free slot, and the chosen slot ID is shown on the port during the same cycle. The reset input is taken as already released in step with the clock.

Top module: `thr_sched`

## Requirements
- R1: After reset all slots are free. `stall` is 1 and `issue_valid`, `load_full` and `ret_err` are 0.
- R2: When `load_valid` is 1 and a slot is free, the program counter, register base and tag are written into the lowest-numbered free slot. That slot number appears on `load_tid` in the same cycle, and the slot is ready from the next cycle. Tag codes are 0 for vertex, 1 for primitive and 2 for fragment.
- R3: While every slot is occupied, `load_full` is 1 and a load request has no effect on any slot or on the issue sequence.
- R4: In each cycle with at least one eligible thread, `issue_valid` is 1 and `issue_tid`, `issue_pc`, `issue_rf_base` and `issue_src` describe the granted slot. With no eligible thread, `issue_valid` is 0 and `stall` is 1.
- R5: The round-robin search begins at the slot after the one issued last, wrapping from slot 15 to slot 0. After reset the first search begins at slot 0.
- R6: `issue_op` applies to the issued thread. 0 moves the program counter on by one and keeps the thread ready. 1 moves the program counter on by one and blocks the thread. 2 loads `issue_target` into the program counter and keeps the thread ready. 3 frees the slot.
- R7: A return (`ret_valid` with `ret_tid`) for a blocked thread makes that thread ready. The return takes effect before arbitration, so the thread can be issued in the same cycle.
- R8: A return for a thread that is not blocked changes no state. `ret_err` is 1 in the following cycle, for one cycle only.
- R9: A slot freed by operation 3 is free from the next cycle and can take a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Request to create a thread |
| load_src | input | 2 | Stage tag of the new thread |
| load_pc | input | 16 | Start program counter |
| load_rf_base | input | 8 | Register-file base of the new thread |
| load_tid | output | 4 | Slot that a load in this cycle fills |
| load_full | output | 1 | No slot is free |
| ret_valid | input | 1 | Memory data came back |
| ret_tid | input | 4 | Thread that the returned data belongs to |
| ret_err | output | 1 | The previous cycle's return named a thread that was not blocked |
| issue_op | input | 2 | Engine's decision for the issued thread |
| issue_target | input | 16 | New program counter for operation 2 |
| issue_valid | output | 1 | A thread is issued this cycle |
| issue_tid | output | 4 | Issued thread ID |
| issue_pc | output | 16 | Program counter of the issued thread |
| issue_rf_base | output | 8 | Register base of the issued thread |
| issue_src | output | 2 | Stage tag of the issued thread |
| stall | output | 1 | No thread can run this cycle |

## Verification
The properties assume that `issue_op` and `issue_target` are settled before the edge of any cycle in which `issue_valid` is 1. They also assume that return and load inputs carry defined values. The bench meets these assumptions by changing all inputs shortly after the falling edge. It chooses each cycle's operation from its own prediction of which thread is granted, so the engine's answer always matches the slot being issued. It deliberately sends returns to ready threads and to free slots, because the error flag and the no-effect rule in R8 must hold for them as well.

// File: rtl/thr_sched_pkg.sv
package thr_sched_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE    = 2'd0,
    SLOT_READY   = 2'd1,
    SLOT_BLOCKED = 2'd2
  } slot_state_e;

  typedef enum logic [1:0] {
    OP_STEP = 2'd0,
    OP_MEM  = 2'd1,
    OP_JUMP = 2'd2,
    OP_DONE = 2'd3
  } issue_op_e;

  localparam logic [1:0] SRC_VERTEX = 2'd0;
  localparam logic [1:0] SRC_PRIM   = 2'd1;
  localparam logic [1:0] SRC_FRAG   = 2'd2;

endpackage

// File: rtl/thr_rr_arb.sv
module thr_rr_arb #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv_en,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_d;

  always_comb begin
    int cand;
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 1; k <= N; k++) begin
      cand = int'(ptr_q) + k;
      if (cand >= N) cand = cand - N;
      if (!gnt_valid && req[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(cand);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv_en && gnt_valid) ptr_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IW'(N - 1);
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/thr_free_pick.sv
module thr_free_pick #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  free_vec,
  output logic          any_free,
  output logic [IW-1:0] free_idx
);

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (free_vec[k]) begin
        any_free = 1'b1;
        free_idx = IW'(k);
      end
    end
  end

endmodule

// File: rtl/thr_ctx_store.sv
module thr_ctx_store #(
  parameter int N     = 16,
  parameter int PC_W  = 16,
  parameter int RF_W  = 8,
  parameter int SRC_W = 2,
  localparam int IW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IW-1:0]    ld_idx,
  input  logic [PC_W-1:0]  ld_pc,
  input  logic [RF_W-1:0]  ld_rf,
  input  logic [SRC_W-1:0] ld_src,
  input  logic             pc_en,
  input  logic [IW-1:0]    pc_idx,
  input  logic [PC_W-1:0]  pc_val,
  input  logic [IW-1:0]    rd_idx,
  output logic [PC_W-1:0]  rd_pc,
  output logic [RF_W-1:0]  rd_rf,
  output logic [SRC_W-1:0] rd_src
);

  logic [N*PC_W-1:0]  pc_flat;
  logic [N*RF_W-1:0]  rf_flat;
  logic [N*SRC_W-1:0] src_flat;

  for (genvar g = 0; g < N; g++) begin : slot_g
    logic [PC_W-1:0]  pc_q,  pc_d;
    logic [RF_W-1:0]  rf_q,  rf_d;
    logic [SRC_W-1:0] src_q, src_d;
    logic             ld_hit, pc_hit;

    assign ld_hit = ld_en && (ld_idx == IW'(g));
    assign pc_hit = pc_en && (pc_idx == IW'(g));

    always_comb begin
      pc_d  = pc_q;
      rf_d  = rf_q;
      src_d = src_q;
      if (pc_hit) pc_d = pc_val;
      if (ld_hit) begin
        pc_d  = ld_pc;
        rf_d  = ld_rf;
        src_d = ld_src;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q  <= '0;
        rf_q  <= '0;
        src_q <= '0;
      end else if (ld_hit || pc_hit) begin
        pc_q  <= pc_d;
        rf_q  <= rf_d;
        src_q <= src_d;
      end
    end

    assign pc_flat[g*PC_W +: PC_W]    = pc_q;
    assign rf_flat[g*RF_W +: RF_W]    = rf_q;
    assign src_flat[g*SRC_W +: SRC_W] = src_q;
  end

  assign rd_pc  = pc_flat[rd_idx*PC_W +: PC_W];
  assign rd_rf  = rf_flat[rd_idx*RF_W +: RF_W];
  assign rd_src = src_flat[rd_idx*SRC_W +: SRC_W];

endmodule

// File: rtl/thr_sched.sv
module thr_sched
  import thr_sched_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  parameter int PC_W        = 16,
  parameter int RF_W        = 8,
  parameter int SRC_W       = 2,
  localparam int IW         = $clog2(NUM_THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [SRC_W-1:0] load_src,
  input  logic [PC_W-1:0]  load_pc,
  input  logic [RF_W-1:0]  load_rf_base,
  output logic [IW-1:0]    load_tid,
  output logic             load_full,
  input  logic             ret_valid,
  input  logic [IW-1:0]    ret_tid,
  output logic             ret_err,
  input  logic [1:0]       issue_op,
  input  logic [PC_W-1:0]  issue_target,
  output logic             issue_valid,
  output logic [IW-1:0]    issue_tid,
  output logic [PC_W-1:0]  issue_pc,
  output logic [RF_W-1:0]  issue_rf_base,
  output logic [SRC_W-1:0] issue_src,
  output logic             stall
);

  slot_state_e st_q [NUM_THREADS];
  slot_state_e st_d [NUM_THREADS];

  logic [NUM_THREADS-1:0] rdy_vec, blk_vec, free_vec, elig_vec;
  logic                   wake_hit, bad_ret;
  logic                   any_free, load_acc;
  logic [IW-1:0]          free_idx;
  logic                   gnt_valid;
  logic [IW-1:0]          gnt_idx;
  logic                   ret_err_q, ret_err_d;
  logic                   pc_en;
  logic [PC_W-1:0]        pc_val;
  issue_op_e              op;

  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) begin
      rdy_vec[i]  = (st_q[i] == SLOT_READY);
      blk_vec[i]  = (st_q[i] == SLOT_BLOCKED);
      free_vec[i] = (st_q[i] == SLOT_FREE);
    end
  end

  assign wake_hit = ret_valid && blk_vec[ret_tid];
  assign bad_ret  = ret_valid && !blk_vec[ret_tid];

  always_comb begin
    elig_vec = rdy_vec;
    if (wake_hit) elig_vec[ret_tid] = 1'b1;
  end

  thr_rr_arb #(.N(NUM_THREADS)) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (elig_vec),
    .adv_en    (gnt_valid),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  thr_free_pick #(.N(NUM_THREADS)) pick_i (
    .free_vec (free_vec),
    .any_free (any_free),
    .free_idx (free_idx)
  );

  assign load_acc  = load_valid && any_free;
  assign load_tid  = free_idx;
  assign load_full = !any_free;

  assign op = issue_op_e'(issue_op);

  always_comb begin
    pc_en  = gnt_valid && (op != OP_DONE);
    pc_val = (op == OP_JUMP) ? issue_target : (issue_pc + PC_W'(1));
  end

  thr_ctx_store #(
    .N     (NUM_THREADS),
    .PC_W  (PC_W),
    .RF_W  (RF_W),
    .SRC_W (SRC_W)
  ) ctx_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (load_acc),
    .ld_idx (free_idx),
    .ld_pc  (load_pc),
    .ld_rf  (load_rf_base),
    .ld_src (load_src),
    .pc_en  (pc_en),
    .pc_idx (gnt_idx),
    .pc_val (pc_val),
    .rd_idx (gnt_idx),
    .rd_pc  (issue_pc),
    .rd_rf  (issue_rf_base),
    .rd_src (issue_src)
  );

  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) begin
      st_d[i] = st_q[i];
      if (wake_hit && (ret_tid == IW'(i))) st_d[i] = SLOT_READY;
      if (gnt_valid && (gnt_idx == IW'(i))) begin
        unique case (op)
          OP_MEM:  st_d[i] = SLOT_BLOCKED;
          OP_DONE: st_d[i] = SLOT_FREE;
          default: st_d[i] = SLOT_READY;
        endcase
      end
      if (load_acc && (free_idx == IW'(i))) st_d[i] = SLOT_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THREADS; i++) st_q[i] <= SLOT_FREE;
    end else begin
      for (int i = 0; i < NUM_THREADS; i++) st_q[i] <= st_d[i];
    end
  end

  assign ret_err_d = bad_ret;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ret_err_q <= 1'b0;
    else        ret_err_q <= ret_err_d;
  end

  assign ret_err     = ret_err_q;
  assign issue_valid = gnt_valid;
  assign issue_tid   = gnt_idx;
  assign stall       = !gnt_valid;

endmodule

// File: rtl/thr_sched_chk.sv
module thr_sched_chk #(
  parameter int NUM_THREADS = 16,
  localparam int IW         = $clog2(NUM_THREADS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load_valid,
  input logic [IW-1:0]          load_tid,
  input logic                   load_full,
  input logic                   ret_valid,
  input logic [IW-1:0]          ret_tid,
  input logic                   ret_err,
  input logic [1:0]             issue_op,
  input logic                   issue_valid,
  input logic [IW-1:0]          issue_tid,
  input logic                   stall,
  input logic [NUM_THREADS-1:0] rdy_vec,
  input logic [NUM_THREADS-1:0] blk_vec
);

  assert_issue_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (rdy_vec[issue_tid] ||
                     (ret_valid && blk_vec[ret_tid] && (ret_tid == issue_tid))));

  assert_stall_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ((rdy_vec == '0) && !(ret_valid && blk_vec[ret_tid])));

  assert_bad_ret_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !blk_vec[ret_tid]) |=> ret_err);

  assert_good_ret_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_valid || blk_vec[ret_tid]) |=> !ret_err);

  assert_load_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && !load_full) |=> rdy_vec[$past(load_tid)]);

  assert_mem_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (issue_op == 2'd1)) |=> blk_vec[$past(issue_tid)]);

  assert_wake_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && blk_vec[ret_tid] && !(issue_valid && (issue_tid == ret_tid)))
      |=> rdy_vec[$past(ret_tid)]);

endmodule

bind thr_sched thr_sched_chk #(.NUM_THREADS(NUM_THREADS)) chk_i (.*);

// File: tb/thr_sched_tb_top.sv
module thr_sched_tb_top;

  logic        clk;
  logic        rst_n;
  logic        load_valid;
  logic [1:0]  load_src;
  logic [15:0] load_pc;
  logic [7:0]  load_rf_base;
  logic [3:0]  load_tid;
  logic        load_full;
  logic        ret_valid;
  logic [3:0]  ret_tid;
  logic        ret_err;
  logic [1:0]  issue_op;
  logic [15:0] issue_target;
  logic        issue_valid;
  logic [3:0]  issue_tid;
  logic [15:0] issue_pc;
  logic [7:0]  issue_rf_base;
  logic [1:0]  issue_src;
  logic        stall;

  thr_sched dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    bit        v;
    bit [3:0]  tid;
    bit [15:0] pc;
    bit [7:0]  rf;
    bit [1:0]  src;
    bit        full;
    bit        lchk;
    bit [3:0]  ltid;
    bit        err;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int        m_st  [16];
  bit [15:0] m_pc  [16];
  bit [7:0]  m_rf  [16];
  bit [1:0]  m_src [16];
  int        m_ptr;
  bit        m_err;

  task automatic chk(input string tag, input string name,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic cyc(input bit rv, input int rt, input bit lv,
                     input bit [1:0] lsrc, input bit [15:0] lpc,
                     input bit [7:0] lrf, input bit [1:0] op,
                     input bit [15:0] tgt, input string tag);
    exp_t e;
    bit full, wake, gv;
    int ltid, gt, c;
    @(negedge clk);
    #1;
    full = 1; ltid = 0;
    for (int k = 15; k >= 0; k--) if (m_st[k] == 0) begin full = 0; ltid = k; end
    wake = rv && (m_st[rt] == 2);
    gv = 0; gt = 0;
    for (int k = 1; k <= 16; k++) begin
      c = (m_ptr + k) % 16;
      if (!gv && ((m_st[c] == 1) || (wake && c == rt))) begin gv = 1; gt = c; end
    end
    e.v = gv; e.tid = gt[3:0]; e.pc = m_pc[gt]; e.rf = m_rf[gt]; e.src = m_src[gt];
    e.full = full; e.lchk = lv; e.ltid = ltid[3:0]; e.err = m_err;
    ret_valid = rv; ret_tid = rt[3:0];
    load_valid = lv; load_src = lsrc; load_pc = lpc; load_rf_base = lrf;
    issue_op = op; issue_target = tgt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (wake) m_st[rt] = 1;
    if (gv) begin
      m_ptr = gt;
      case (op)
        2'd0: begin m_pc[gt] = m_pc[gt] + 16'd1; m_st[gt] = 1; end
        2'd1: begin m_pc[gt] = m_pc[gt] + 16'd1; m_st[gt] = 2; end
        2'd2: begin m_pc[gt] = tgt; m_st[gt] = 1; end
        default: m_st[gt] = 0;
      endcase
    end
    if (lv && !full) begin
      m_st[ltid] = 1; m_pc[ltid] = lpc; m_rf[ltid] = lrf; m_src[ltid] = lsrc;
    end
    m_err = rv && !wake;
  endtask

  exp_t  mon_e;
  string mon_t;
  always @(negedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      chk(mon_t, "issue_valid", {31'd0, issue_valid}, {31'd0, mon_e.v});
      chk(mon_t, "stall", {31'd0, stall}, {31'd0, !mon_e.v});
      if (mon_e.v) begin
        chk(mon_t, "issue_tid", {28'd0, issue_tid}, {28'd0, mon_e.tid});
        chk(mon_t, "issue_pc", {16'd0, issue_pc}, {16'd0, mon_e.pc});
        chk(mon_t, "issue_rf_base", {24'd0, issue_rf_base}, {24'd0, mon_e.rf});
        chk(mon_t, "issue_src", {30'd0, issue_src}, {30'd0, mon_e.src});
      end
      chk(mon_t, "load_full", {31'd0, load_full}, {31'd0, mon_e.full});
      chk(mon_t, "ret_err", {31'd0, ret_err}, {31'd0, mon_e.err});
      if (mon_e.lchk && !mon_e.full)
        chk(mon_t, "load_tid", {28'd0, load_tid}, {28'd0, mon_e.ltid});
    end
  end

  task automatic idle(input int n, input bit [1:0] op, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, op, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_st[i] = 0; m_pc[i] = 0; m_rf[i] = 0; m_src[i] = 0;
    end
    m_ptr = 15; m_err = 0;
    rst_n = 0; load_valid = 0; load_src = 0; load_pc = 0; load_rf_base = 0;
    ret_valid = 0; ret_tid = 0; issue_op = 0; issue_target = 0;
    repeat (3) @(negedge clk);
    #3;
    chk("R1", "stall", {31'd0, stall}, 32'd1);
    chk("R1", "issue_valid", {31'd0, issue_valid}, 32'd0);
    chk("R1", "load_full", {31'd0, load_full}, 32'd0);
    chk("R1", "ret_err", {31'd0, ret_err}, 32'd0);
    @(negedge clk);
    rst_n = 1;

    // R2 load four threads of the three stage kinds, lowest free slot first
    cyc(0, 0, 1, 2'd0, 16'h0100, 8'h10, 2'd0, 0, "R2");
    cyc(0, 0, 1, 2'd1, 16'h0200, 8'h20, 2'd0, 0, "R2");
    cyc(0, 0, 1, 2'd2, 16'h0300, 8'h30, 2'd0, 0, "R2");
    cyc(0, 0, 1, 2'd1, 16'h0400, 8'h40, 2'd0, 0, "R2");
    // R5 rotation across the four threads
    idle(12, 2'd0, "R5");
    // R6 memory references block every thread, then R4 stall
    idle(4, 2'd1, "R6");
    idle(3, 2'd1, "R4");
    // R7 return for thread 2 issues in the same cycle
    cyc(1, 2, 0, 0, 0, 0, 2'd0, 0, "R7");
    // R8 return for a ready thread, then for a free slot
    cyc(1, 2, 0, 0, 0, 0, 2'd0, 0, "R8");
    cyc(1, 9, 0, 0, 0, 0, 2'd0, 0, "R8");
    idle(2, 2'd0, "R8");
    // R7 wake and re-block others
    cyc(1, 0, 0, 0, 0, 0, 2'd1, 0, "R7");
    cyc(1, 1, 0, 0, 0, 0, 2'd1, 0, "R7");
    cyc(1, 3, 0, 0, 0, 0, 2'd1, 0, "R7");
    // R6 jump then finish, R9 reuse of freed slot
    cyc(1, 1, 0, 0, 0, 0, 2'd2, 16'h0800, "R6");
    idle(2, 2'd0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 2'd3, 0, "R6");
    cyc(0, 0, 1, 2'd2, 16'h0900, 8'h90, 2'd0, 0, "R9");
    idle(3, 2'd0, "R9");
    // R3 fill every slot, then loads are ignored
    for (int i = 0; i < 15; i++)
      cyc(0, 0, 1, 2'(i % 3), 16'h1000 + 16'(i * 16), 8'(8'h50 + i), 2'd0, 0, "R2");
    for (int i = 0; i < 4; i++)
      cyc(0, 0, 1, 2'd2, 16'hDEAD, 8'hEE, 2'd0, 0, "R3");
    idle(20, 2'd0, "R5");
    // R6 finish everything, R4 stall, R9 slots free again
    idle(20, 2'd3, "R6");
    idle(2, 2'd0, "R4");
    cyc(1, 5, 0, 0, 0, 0, 2'd0, 0, "R8");
    cyc(0, 0, 1, 2'd0, 16'h0A00, 8'hA0, 2'd0, 0, "R9");
    idle(3, 2'd0, "R9");
    @(negedge clk);
    #5;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule